// File: doc/BRIEF.md
# DMA Request Source Selector

This block routes one of many peripheral event lines to a single DMA channel. An 8-bit control register holds a 4-bit source code and a table-select bit. The table-select bit picks between two cause tables. The primary table covers the external interrupt pin's falling edge, a software trigger, five general timers, three auxiliary timers, three serial ports and A/D completion. The secondary table covers a capture/compare base timer, eight capture/compare channels and both edges of the external interrupt pin.

The chosen event leaves the block as a registered one-cycle request pulse on `dma_req`. Writing the register with its trigger bit set, while the software-trigger code is selected in the primary table, raises a request in the same way.

The external pin is asynchronous. It passes through a synchroniser before edges are detected on it. Peripheral events are one-cycle pulses in the clock domain of the block. The request output is a plain pulse with no back-pressure: the DMA engine must accept it in the cycle it appears, and the block never holds or queues a request.

Top module: `dma_req_sel`

## Requirements
- R1: After reset the register reads 0x00, and `dma_req` stays low until a selected cause occurs.
- R2: Reads return bit 6 and bits 3..0 as last written. Bits 7, 5 and 4 always read 0, so writing 0xFF reads back 0x4F.
- R3: With bit 6 = 0 (primary table), an event pulse at the source named by bits 3..0 produces a request. The codes are: 0010..0110 general timers 0..4, 0111..1001 auxiliary timers 0..2, 1010/1011 serial port 0 transmit/receive, 1100/1101 serial port 2 transmit/receive, 1110 A/D done, and 1111 serial port 1 transmit.
- R4: With bit 6 = 1 (secondary table), the codes are: 0000 capture/compare base timer, 0001 channel 0, 0010 channel 1, 0011 either edge of the interrupt pin, and 0100..1001 channels 2..7.
- R5: With bit 6 = 1, codes 1010..1111 produce no request from any source.
- R6: A write with bit 7 = 1, bit 6 = 0 and bits 3..0 = 0001 produces exactly one request pulse, in the cycle after the write edge. A write with bit 7 = 1 and any other table-select bit or code produces none.
- R7: The external pin passes through two synchroniser stages. Under primary code 0000 only a falling edge requests. Under secondary code 0011 both edges request. The request appears after the third rising clock edge that samples the new pin level.
- R8: An event pulse sampled at a clock edge makes `dma_req` high for exactly the following cycle. Events on consecutive cycles give requests on consecutive cycles.
- R9: Events presented in the cycle of a register write, or in the cycle just after it, produce no request. The software trigger is the exception.
- R10: Events on sources that the current setting does not select have no effect on `dma_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| gp_tmr_evt | input | 5 | General timer 0..4 event pulses |
| aux_tmr_evt | input | 3 | Auxiliary timer 0..2 event pulses |
| ser0_tx_evt | input | 1 | Serial port 0 transmit event |
| ser0_rx_evt | input | 1 | Serial port 0 receive event |
| ser2_tx_evt | input | 1 | Serial port 2 transmit event |
| ser2_rx_evt | input | 1 | Serial port 2 receive event |
| adc_done_evt | input | 1 | A/D conversion complete event |
| ser1_tx_evt | input | 1 | Serial port 1 transmit event |
| cc_base_evt | input | 1 | Capture/compare base timer event |
| cc_ch_evt | input | 8 | Capture/compare channel 0..7 events |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
The bench builds the block with its defaults: a two-stage pin synchroniser and an idle-high pin reset level. With these values the pin latency is exactly three edges, and each pin edge can be tied to its request cycle. With the defaults, every one of the 32 table settings can be swept against all 23 event lines and both pin edges. This exposes any code mapped to the wrong line and any leak from an unselected source. Focused sequences cover the write-mask window, the back-to-back pulse case and the narrow software-trigger condition.

// File: rtl/dma_req_sel_pkg.sv
package dma_req_sel_pkg;
  localparam int REG_W   = 8;
  localparam int CODE_W  = 4;
  localparam int TBL_N   = 1 << CODE_W;
  localparam int TBL_BIT = 6;
  localparam int SWT_BIT = 7;
  localparam int N_GPT   = 5;
  localparam int N_AUXT  = 3;
  localparam int N_CC    = 8;

  localparam logic [CODE_W-1:0] CODE_SWT = 4'b0001;
  localparam logic [REG_W-1:0]  KEEP_MASK = 8'b0100_1111;

  typedef struct packed {
    logic              alt_tbl;
    logic [CODE_W-1:0] code;
  } cause_sel_t;
endpackage

// File: rtl/dma_req_sel_reg.sv
module dma_req_sel_reg
  import dma_req_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output cause_sel_t       cause,
  output logic             swt_fire
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & KEEP_MASK;
  end

  assign rd_data       = ctrl_q;
  assign cause.alt_tbl = ctrl_q[TBL_BIT];
  assign cause.code    = ctrl_q[CODE_W-1:0];

  // trigger decoded from the value being written, not the stored one
  assign swt_fire = wr_en && wr_data[SWT_BIT] && !wr_data[TBL_BIT]
                    && (wr_data[CODE_W-1:0] == CODE_SWT);
endmodule

// File: rtl/dma_req_sel_pin.sv
module dma_req_sel_pin #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall_evt,
  output logic edge_evt
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{IDLE}};
      last_q <= IDLE;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_evt = last_q && !sync_q[STAGES-1];
  assign edge_evt = last_q ^ sync_q[STAGES-1];
endmodule

// File: rtl/dma_req_sel_mux.sv
module dma_req_sel_mux
  import dma_req_sel_pkg::*;
(
  input  cause_sel_t        cause,
  input  logic              pin_fall,
  input  logic              pin_edge,
  input  logic [N_GPT-1:0]  gp_tmr,
  input  logic [N_AUXT-1:0] aux_tmr,
  input  logic              s0_tx,
  input  logic              s0_rx,
  input  logic              s2_tx,
  input  logic              s2_rx,
  input  logic              adc,
  input  logic              s1_tx,
  input  logic              cc_base,
  input  logic [N_CC-1:0]   cc_ch,
  output logic              hit
);
  logic [TBL_N-1:0] pri_vec;
  logic [TBL_N-1:0] alt_vec;

  always_comb begin
    pri_vec    = '0;
    pri_vec[0] = pin_fall;
    // slot 1 is the software code, served by the write path
    for (int i = 0; i < N_GPT; i++)  pri_vec[2 + i] = gp_tmr[i];
    for (int i = 0; i < N_AUXT; i++) pri_vec[2 + N_GPT + i] = aux_tmr[i];
    pri_vec[10] = s0_tx;
    pri_vec[11] = s0_rx;
    pri_vec[12] = s2_tx;
    pri_vec[13] = s2_rx;
    pri_vec[14] = adc;
    pri_vec[15] = s1_tx;
  end

  always_comb begin
    alt_vec    = '0;
    alt_vec[0] = cc_base;
    alt_vec[1] = cc_ch[0];
    alt_vec[2] = cc_ch[1];
    alt_vec[3] = pin_edge;
    for (int i = 2; i < N_CC; i++) alt_vec[2 + i] = cc_ch[i];
  end

  assign hit = cause.alt_tbl ? alt_vec[cause.code] : pri_vec[cause.code];
endmodule

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_req_sel_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              ext_pin,
  input  logic [N_GPT-1:0]  gp_tmr_evt,
  input  logic [N_AUXT-1:0] aux_tmr_evt,
  input  logic              ser0_tx_evt,
  input  logic              ser0_rx_evt,
  input  logic              ser2_tx_evt,
  input  logic              ser2_rx_evt,
  input  logic              adc_done_evt,
  input  logic              ser1_tx_evt,
  input  logic              cc_base_evt,
  input  logic [N_CC-1:0]   cc_ch_evt,
  output logic              dma_req
);
  cause_sel_t cause;
  logic       swt_fire;
  logic       pin_fall, pin_edge;
  logic       src_hit;
  logic       hold_q;
  logic       req_q;

  dma_req_sel_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cause(cause), .swt_fire(swt_fire)
  );

  dma_req_sel_pin #(.STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .fall_evt(pin_fall), .edge_evt(pin_edge)
  );

  dma_req_sel_mux u_mux (
    .cause(cause), .pin_fall(pin_fall), .pin_edge(pin_edge),
    .gp_tmr(gp_tmr_evt), .aux_tmr(aux_tmr_evt),
    .s0_tx(ser0_tx_evt), .s0_rx(ser0_rx_evt),
    .s2_tx(ser2_tx_evt), .s2_rx(ser2_rx_evt),
    .adc(adc_done_evt), .s1_tx(ser1_tx_evt),
    .cc_base(cc_base_evt), .cc_ch(cc_ch_evt), .hit(src_hit)
  );

  // events are blocked in the write cycle and the cycle after it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      hold_q <= wr_en;
      req_q  <= swt_fire | (src_hit & !wr_en & !hold_q);
    end
  end

  assign dma_req = req_q;
endmodule

// File: rtl/dma_req_sel_chk.sv
module dma_req_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [4:0] gp_tmr_evt,
  input logic       dma_req
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] == 1'b0) && (rd_data[5:4] == 2'b00));

  a_r6_soft_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && !wr_data[6] && wr_data[3:0] == 4'b0001) |=> dma_req);

  a_r9_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(wr_data[7] && !wr_data[6] && wr_data[3:0] == 4'b0001)) |=> !dma_req);

  a_r5_unlisted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6] && rd_data[3:0] > 4'd9 && !wr_en) |=> !dma_req);

  a_r3_timer0_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == 8'h02 && !wr_en && !$past(wr_en) && gp_tmr_evt[0]) |=> dma_req);
endmodule

bind dma_req_sel dma_req_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .gp_tmr_evt(gp_tmr_evt), .dma_req(dma_req)
);

// File: tb/dma_req_sel_bench.sv
module dma_req_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        pin = 1'b1;
  logic [22:0] ev = '0;
  logic        dma_req;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_req_sel u_dma_req_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ext_pin(pin),
    .gp_tmr_evt(ev[4:0]), .aux_tmr_evt(ev[7:5]),
    .ser0_tx_evt(ev[8]), .ser0_rx_evt(ev[9]),
    .ser2_tx_evt(ev[10]), .ser2_rx_evt(ev[11]),
    .adc_done_evt(ev[12]), .ser1_tx_evt(ev[13]),
    .cc_base_evt(ev[14]), .cc_ch_evt(ev[22:15]),
    .dma_req(dma_req)
  );

  // monitor: pops expected request cycles and compares
  always @(negedge clk) begin
    if (rst_n) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s: no request seen, actual cycle none expected %0d", tag_q[0], exp_q[0]);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
      if (dma_req) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front()); void'(tag_q.pop_front());
        end else begin
          errors++;
          $display("FAIL %s: request at cycle %0d, expected %0d", cur_tag, cyc,
                   (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic push(int at, string tag);
    exp_q.push_back(at); tag_q.push_back(tag);
  endtask

  task automatic wr(logic [7:0] d, string tag);
    @(negedge clk);
    cur_tag = tag; wr_en = 1'b1; wr_data = d;
    if (d[7] && !d[6] && d[3:0] == 4'b0001) push(cyc + 1, tag);
    else checks++;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic fire(int idx, bit want, string tag);
    @(negedge clk);
    cur_tag = tag; ev[idx] = 1'b1;
    if (want) push(cyc + 1, tag); else checks++;
    @(negedge clk); ev = '0;
    @(negedge clk);
  endtask

  task automatic pin_set(logic v, bit want, string tag);
    @(negedge clk);
    cur_tag = tag; pin = v;
    if (want) push(cyc + 3, tag); else checks++;
    repeat (4) @(negedge clk);
  endtask

  // expected line index from the requirement tables, -1 none, -2 pin
  function automatic int exp_idx(bit alt, int code);
    if (!alt) begin
      if (code == 0) return -2;
      if (code == 1) return -1;
      return code - 2;
    end
    if (code == 0) return 14;
    if (code == 1) return 15;
    if (code == 2) return 16;
    if (code == 3) return -2;
    if (code <= 9) return code + 13;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", rd_data, 8'h00);
    chk("R1", {7'b0, dma_req}, 8'h00);
    fire(0, 1'b0, "R1");
    fire(14, 1'b0, "R1");

    wr(8'hFF, "R2"); chk("R2", rd_data, 8'h4F);
    wr(8'h35, "R2"); chk("R2", rd_data, 8'h05);

    // software trigger cases
    wr(8'hB1, "R6"); chk("R2", rd_data, 8'h01);
    wr(8'h81, "R6");
    wr(8'hC1, "R6");
    wr(8'h82, "R6");
    wr(8'h01, "R6");
    fire(0, 1'b0, "R10");

    // full table sweep
    for (int t = 0; t < 2; t++) begin
      for (int c = 0; c < 16; c++) begin
        string tg;
        int    e;
        e  = exp_idx(t[0], c);
        tg = (t == 0) ? "R3" : ((c <= 9) ? "R4" : "R5");
        wr({1'b0, t[0], 2'b00, c[3:0]}, tg);
        for (int i = 0; i < 23; i++)
          fire(i, (i == e), (i == e) ? tg : ((t == 1 && c > 9) ? "R5" : "R10"));
        pin_set(1'b0, (e == -2), "R7");
        pin_set(1'b1, (e == -2) && (t == 1), "R7");
      end
    end

    // back-to-back events on general timer 0 (code 0010)
    wr(8'h02, "R8");
    @(negedge clk);
    cur_tag = "R8"; ev[0] = 1'b1; push(cyc + 1, "R8");
    @(negedge clk); push(cyc + 1, "R8");
    @(negedge clk); ev = '0;
    repeat (3) @(negedge clk);
    fire(0, 1'b1, "R8");

    // write mask window
    @(negedge clk);
    cur_tag = "R9"; wr_en = 1'b1; wr_data = 8'h02; ev[0] = 1'b1; checks++;
    @(negedge clk); wr_en = 1'b0; checks++;
    @(negedge clk); ev[0] = 1'b0;
    @(negedge clk); ev[0] = 1'b1; push(cyc + 1, "R9");
    @(negedge clk); ev[0] = 1'b0;
    repeat (3) @(negedge clk);

    // pin edge under other selection ignored
    pin_set(1'b0, 1'b0, "R10");
    pin_set(1'b1, 1'b0, "R10");

    repeat (4) @(negedge clk);
    while (exp_q.size() > 0) begin
      checks++; errors++;
      $display("FAIL %s: no request seen, actual none expected %0d", tag_q[0], exp_q[0]);
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule